// File: doc/BRIEF.md
# Event-Driven Timestamp Receiver

This block rebuilds wall-clock time at a receiving node from a stream of 8-bit event codes, one code per cycle, each qualified by a valid flag. Two dedicated codes each carry one bit of the next seconds value. These bits are shifted into a pending register, most significant bit first. A separate tick code advances a 32-bit sub-second counter. A reset code then moves the pending value into the live seconds register and restarts the sub-second count from zero.

Every incoming event may carry two action flags, which an upstream mapping stage supplies. The capture flag copies the current time into a readable register. The store flag pushes the event code and the current time into an event FIFO, which the host drains through a show-ahead read port. When the FIFO is full it refuses new entries instead of overwriting old ones. It also raises a sticky flag that tells the host events were lost.

Top module: `evt_timestamp_rx`

## Requirements
- R1: After reset the captured seconds and sub-second outputs are zero, the FIFO holds zero entries (fifo_empty=1, fifo_full=0), the drop flag is 0, and the live seconds, sub-second and pending values are all zero.
- R2: A valid event with code 0x70 shifts a 0 into the 32-bit pending seconds value and code 0x71 shifts a 1. The new bit enters at bit 0 and older bits move toward bit 31, so the first bit received ends up most significant.
- R3: A valid event with code 0x7D copies the pending value into the seconds register and sets the sub-second counter to zero. The pending value itself is kept.
- R4: A valid event with code 0x7C adds one to the sub-second counter. A counter already at all ones stays at all ones.
- R5: An event presented with evt_valid low changes nothing: not the time, not the pending value, not the captured register and not the FIFO, whatever its code or action flags.
- R6: A valid event with act_latch high loads lat_secs/lat_sub, one cycle later, with the seconds and sub-second values held before that event's own effect. Otherwise both outputs hold their values.
- R7: A valid event with act_save high, while the FIFO is not full, appends the entry {code, seconds, sub-second}, which holds the values from before the event's own effect. Entries leave oldest first. While the FIFO is not empty, the oldest entry is shown on fifo_code/fifo_secs/fifo_sub, and fifo_rd removes it.
- R8: A store request that arrives while fifo_count equals the depth (8 by default) is dropped, even if fifo_rd is high in the same cycle. The stored entries are not changed, and fifo_ovf is set to 1.
- R9: ovf_clr clears fifo_ovf. A drop in the same cycle wins, and the flag stays 1.
- R10: fifo_rd while the FIFO is empty has no effect. The count stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_code | input | 8 | Received event code |
| evt_valid | input | 1 | evt_code holds an event this cycle |
| act_latch | input | 1 | Capture the current time for this event |
| act_save | input | 1 | Store this event and its time in the FIFO |
| fifo_rd | input | 1 | Host removes the oldest FIFO entry |
| ovf_clr | input | 1 | Host clears the drop flag |
| lat_secs | output | 32 | Captured seconds |
| lat_sub | output | 32 | Captured sub-second count |
| fifo_code | output | 8 | Code of the oldest FIFO entry |
| fifo_secs | output | 32 | Seconds of the oldest FIFO entry |
| fifo_sub | output | 32 | Sub-second count of the oldest FIFO entry |
| fifo_count | output | 4 | Number of stored entries |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds depth entries |
| fifo_ovf | output | 1 | Sticky flag: a store request was dropped |

## Verification
The bench shifts an asymmetric bit pattern (1,1,0 gives 6, not 3), so a design that shifts toward the wrong end produces a wrong seconds value. It captures time on the tick and reset events themselves, which exposes a design that samples after the event's own update instead of before it. A second instance with a narrow sub-second counter is driven past all ones, where a wrapping counter would read a small value again. The FIFO is filled and then given one more store request, once alone and once together with a read. This catches a design that overwrites entries, that admits the entry in the same cycle as the read, or that lets a clear win over a drop.

// File: rtl/ts_rx_pkg.sv
package ts_rx_pkg;

    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_BIT0  = 8'h70;
    localparam logic [CODE_W-1:0] CODE_BIT1  = 8'h71;
    localparam logic [CODE_W-1:0] CODE_TICK  = 8'h7C;
    localparam logic [CODE_W-1:0] CODE_RESYN = 8'h7D;

    typedef enum logic [2:0] {
        TOP_NONE,
        TOP_SHIFT0,
        TOP_SHIFT1,
        TOP_TICK,
        TOP_LOAD
    } time_op_e;

    function automatic time_op_e decode_op(input logic [CODE_W-1:0] code,
                                           input logic valid);
        time_op_e op;
        op = TOP_NONE;
        if (valid) begin
            case (code)
                CODE_BIT0:  op = TOP_SHIFT0;
                CODE_BIT1:  op = TOP_SHIFT1;
                CODE_TICK:  op = TOP_TICK;
                CODE_RESYN: op = TOP_LOAD;
                default:    op = TOP_NONE;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/ts_evt_decode.sv
module ts_evt_decode
    import ts_rx_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              valid,
    output time_op_e          op
);

    always_comb begin
        op = decode_op(code, valid);
    end

endmodule

// File: rtl/ts_time_core.sv
module ts_time_core
    import ts_rx_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  time_op_e         op,
    output logic [SEC_W-1:0] secs,
    output logic [SUB_W-1:0] sub
);

    typedef struct packed {
        logic [SEC_W-1:0] pend;
        logic [SEC_W-1:0] secs;
        logic [SUB_W-1:0] sub;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            TOP_SHIFT0: st_d.pend = {st_q.pend[SEC_W-2:0], 1'b0};
            TOP_SHIFT1: st_d.pend = {st_q.pend[SEC_W-2:0], 1'b1};
            TOP_TICK: begin
                if (st_q.sub != {SUB_W{1'b1}}) begin
                    st_d.sub = st_q.sub + SUB_W'(1);
                end
            end
            TOP_LOAD: begin
                st_d.secs = st_q.pend;
                st_d.sub  = '0;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign secs = st_q.secs;
    assign sub  = st_q.sub;

endmodule

// File: rtl/ts_capture_reg.sv
module ts_capture_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (cap) begin
            val_d = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign dout = val_q;

endmodule

// File: rtl/ts_event_fifo.sv
module ts_event_fifo #(
    parameter int W     = 72,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    input  logic             ovf_clr,
    output logic [W-1:0]     head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic is_full, is_empty, do_push, do_pop, drop;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + PTR_W'(1);
    endfunction

    always_comb begin
        is_full  = (st_q.cnt == CNT_W'(DEPTH));
        is_empty = (st_q.cnt == '0);
        do_push  = push && !is_full;
        drop     = push && is_full;
        do_pop   = pop && !is_empty;

        st_d = st_q;
        if (do_push) begin
            st_d.wr = next_ptr(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = next_ptr(st_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end
        if (drop) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr] <= push_data;
        end
    end

    assign head  = mem_q[st_q.rd];
    assign count = st_q.cnt;
    assign empty = is_empty;
    assign full  = is_full;
    assign ovf   = st_q.ovf;

endmodule

// File: rtl/evt_timestamp_rx.sv
module evt_timestamp_rx
    import ts_rx_pkg::*;
#(
    parameter int SEC_W      = 32,
    parameter int SUB_W      = 32,
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              evt_valid,
    input  logic              act_latch,
    input  logic              act_save,
    input  logic              fifo_rd,
    input  logic              ovf_clr,
    output logic [SEC_W-1:0]  lat_secs,
    output logic [SUB_W-1:0]  lat_sub,
    output logic [CODE_W-1:0] fifo_code,
    output logic [SEC_W-1:0]  fifo_secs,
    output logic [SUB_W-1:0]  fifo_sub,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              fifo_ovf
);

    localparam int TS_W    = SEC_W + SUB_W;
    localparam int ENTRY_W = CODE_W + TS_W;

    time_op_e           op;
    logic [SEC_W-1:0]   cur_secs;
    logic [SUB_W-1:0]   cur_sub;
    logic [TS_W-1:0]    cap_out;
    logic [ENTRY_W-1:0] head;
    logic               cap_en, push_en;

    assign cap_en  = evt_valid && act_latch;
    assign push_en = evt_valid && act_save;

    ts_evt_decode u_dec (
        .code  (evt_code),
        .valid (evt_valid),
        .op    (op)
    );

    ts_time_core #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .secs  (cur_secs),
        .sub   (cur_sub)
    );

    ts_capture_reg #(.W(TS_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap_en),
        .din   ({cur_secs, cur_sub}),
        .dout  (cap_out)
    );

    ts_event_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_en),
        .push_data ({evt_code, cur_secs, cur_sub}),
        .pop       (fifo_rd),
        .ovf_clr   (ovf_clr),
        .head      (head),
        .count     (fifo_count),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .ovf       (fifo_ovf)
    );

    assign lat_secs  = cap_out[TS_W-1:SUB_W];
    assign lat_sub   = cap_out[SUB_W-1:0];
    assign fifo_code = head[ENTRY_W-1:TS_W];
    assign fifo_secs = head[TS_W-1:SUB_W];
    assign fifo_sub  = head[SUB_W-1:0];

endmodule

// File: rtl/evt_timestamp_rx_chk.sv
module evt_timestamp_rx_chk #(
    parameter int SEC_W      = 32,
    parameter int SUB_W      = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       evt_code,
    input logic             evt_valid,
    input logic             act_latch,
    input logic             act_save,
    input logic             fifo_rd,
    input logic             ovf_clr,
    input logic [SEC_W-1:0] lat_secs,
    input logic [SUB_W-1:0] lat_sub,
    input logic [SEC_W-1:0] cur_secs,
    input logic [SUB_W-1:0] cur_sub,
    input logic [CNT_W-1:0] fifo_count,
    input logic             fifo_full,
    input logic             fifo_ovf
);

    // R3
    resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 8'h7D) |=> (cur_sub == '0));

    // R4
    tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 8'h7C && cur_sub != {SUB_W{1'b1}})
        |=> (cur_sub == $past(cur_sub) + SUB_W'(1)));

    // R4
    tick_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 8'h7C && cur_sub == {SUB_W{1'b1}})
        |=> (cur_sub == {SUB_W{1'b1}}));

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_valid && act_latch) |=> ($stable(lat_secs) && $stable(lat_sub)));

    // R6
    latch_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && act_latch)
        |=> (lat_secs == $past(cur_secs) && lat_sub == $past(cur_sub)));

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && act_save && fifo_full && !fifo_rd)
        |=> (fifo_ovf && fifo_count == $past(fifo_count)));

    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(evt_valid && act_save && fifo_full)) |=> !fifo_ovf);

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(FIFO_DEPTH));

endmodule

bind evt_timestamp_rx evt_timestamp_rx_chk #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_code(evt_code), .evt_valid(evt_valid),
    .act_latch(act_latch), .act_save(act_save), .fifo_rd(fifo_rd),
    .ovf_clr(ovf_clr), .lat_secs(lat_secs), .lat_sub(lat_sub),
    .cur_secs(cur_secs), .cur_sub(cur_sub), .fifo_count(fifo_count),
    .fifo_full(fifo_full), .fifo_ovf(fifo_ovf)
);

// File: tb/evt_timestamp_rx_test.sv
module evt_timestamp_rx_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_code = '0;
    logic        evt_valid = 1'b0, act_latch = 1'b0, act_save = 1'b0;
    logic        fifo_rd = 1'b0, ovf_clr = 1'b0;
    logic [31:0] lat_secs, lat_sub, fifo_secs, fifo_sub;
    logic [7:0]  fifo_code;
    logic [3:0]  fifo_count;
    logic        fifo_empty, fifo_full, fifo_ovf;

    logic [31:0] s_lat_secs, s_fifo_secs;
    logic [3:0]  s_lat_sub, s_fifo_sub;
    logic [7:0]  s_fifo_code;
    logic [3:0]  s_fifo_count;
    logic        s_empty, s_full, s_ovf;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timestamp_rx uut (
        .clk(clk), .rst_n(rst_n), .evt_code(evt_code), .evt_valid(evt_valid),
        .act_latch(act_latch), .act_save(act_save), .fifo_rd(fifo_rd),
        .ovf_clr(ovf_clr), .lat_secs(lat_secs), .lat_sub(lat_sub),
        .fifo_code(fifo_code), .fifo_secs(fifo_secs), .fifo_sub(fifo_sub),
        .fifo_count(fifo_count), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .fifo_ovf(fifo_ovf)
    );

    evt_timestamp_rx #(.SUB_W(4)) uut_sat (
        .clk(clk), .rst_n(rst_n), .evt_code(evt_code), .evt_valid(evt_valid),
        .act_latch(act_latch), .act_save(act_save), .fifo_rd(fifo_rd),
        .ovf_clr(ovf_clr), .lat_secs(s_lat_secs), .lat_sub(s_lat_sub),
        .fifo_code(s_fifo_code), .fifo_secs(s_fifo_secs), .fifo_sub(s_fifo_sub),
        .fifo_count(s_fifo_count), .fifo_empty(s_empty), .fifo_full(s_full),
        .fifo_ovf(s_ovf)
    );

    // code, latch flag, expected lat_secs, expected lat_sub after the event
    localparam logic [72:0] VEC [15] = '{
        {8'h71, 1'b0, 32'd0,  32'd0},
        {8'h71, 1'b0, 32'd0,  32'd0},
        {8'h70, 1'b0, 32'd0,  32'd0},
        {8'h7C, 1'b0, 32'd0,  32'd0},
        {8'h7C, 1'b0, 32'd0,  32'd0},
        {8'h20, 1'b1, 32'd0,  32'd2},
        {8'h7D, 1'b1, 32'd0,  32'd2},
        {8'h7C, 1'b0, 32'd0,  32'd2},
        {8'h42, 1'b1, 32'd6,  32'd1},
        {8'h71, 1'b0, 32'd6,  32'd1},
        {8'h7D, 1'b0, 32'd6,  32'd1},
        {8'h7C, 1'b0, 32'd6,  32'd1},
        {8'h7C, 1'b0, 32'd6,  32'd1},
        {8'h7C, 1'b1, 32'd13, 32'd2},
        {8'h55, 1'b1, 32'd13, 32'd3}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] code, input logic v, input logic lat,
                       input logic sav, input logic rd, input logic clr);
        @(negedge clk);
        evt_code = code; evt_valid = v; act_latch = lat; act_save = sav;
        fifo_rd = rd; ovf_clr = clr;
        @(negedge clk);
        evt_valid = 1'b0; act_latch = 1'b0; act_save = 1'b0;
        fifo_rd = 1'b0; ovf_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 lat_secs", 64'(lat_secs), 64'd0);
        chk("R1 lat_sub", 64'(lat_sub), 64'd0);
        chk("R1 count", 64'(fifo_count), 64'd0);
        chk("R1 empty/full/ovf", 64'({fifo_empty, fifo_full, fifo_ovf}), 64'b100);

        // R2 R3 R4 R6: table walk
        for (int i = 0; i < 15; i++) begin
            logic [72:0] v;
            v = VEC[i];
            cyc(v[72:65], 1'b1, v[64], 1'b0, 1'b0, 1'b0);
            chk($sformatf("R2/R3/R4/R6 row %0d secs", i), 64'(lat_secs), 64'(v[63:32]));
            chk($sformatf("R2/R3/R4/R6 row %0d sub", i), 64'(lat_sub), 64'(v[31:0]));
        end

        // R5 invalid events ignored
        cyc(8'h7C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R5 lat unchanged", 64'(lat_sub), 64'd3);
        chk("R5 fifo untouched", 64'(fifo_count), 64'd0);
        cyc(8'h7D, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(8'h33, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 time kept secs", 64'(lat_secs), 64'd13);
        chk("R5 time kept sub", 64'(lat_sub), 64'd3);

        // R4 saturation on narrow instance, R3 pending kept
        cyc(8'h7D, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) cyc(8'h7C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(8'h34, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R4 wide count", 64'(lat_sub), 64'd20);
        chk("R4 saturate", 64'(s_lat_sub), 64'd15);
        chk("R3 pending kept", 64'(lat_secs), 64'd13);

        // R7 fill, R10 ordering later
        for (int i = 0; i < 8; i++) begin
            cyc(8'h7C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
            cyc(8'hA0 + 8'(i), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        end
        chk("R7 count full", 64'(fifo_count), 64'd8);
        chk("R7 full/ovf", 64'({fifo_full, fifo_ovf}), 64'b10);
        chk("R7 head code", 64'(fifo_code), 64'hA0);
        chk("R7 head secs", 64'(fifo_secs), 64'd13);
        chk("R7 head sub", 64'(fifo_sub), 64'd21);

        // R8 drop when full, alone and with a read
        cyc(8'hEE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 ovf set", 64'(fifo_ovf), 64'd1);
        chk("R8 count kept", 64'(fifo_count), 64'd8);
        chk("R8 head kept", 64'(fifo_code), 64'hA0);
        cyc(8'hEF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R8 drop with read count", 64'(fifo_count), 64'd7);
        for (int i = 1; i < 8; i++) begin
            chk($sformatf("R7 order code %0d", i), 64'(fifo_code), 64'(8'hA0 + 8'(i)));
            chk($sformatf("R7 order sub %0d", i), 64'(fifo_sub), 64'(21 + i));
            cyc(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        end
        chk("R7 drained empty", 64'({fifo_empty, fifo_count}), 64'h10);

        // R10 read on empty
        cyc(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 count stays", 64'({fifo_empty, fifo_count}), 64'h10);

        // R9 clear, then set wins over clear
        cyc(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 cleared", 64'(fifo_ovf), 64'd0);
        for (int i = 0; i < 8; i++) cyc(8'hB0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        cyc(8'hB1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R9 drop wins", 64'(fifo_ovf), 64'd1);
        cyc(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 clear after", 64'(fifo_ovf), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule